// File: doc/BRIEF.md
# Cache Way Replacement Selector

This block picks the way to evict from one set of an associative cache with four or eight ways. It keeps its own recency or order state for every set, so the cache does not have to store any. The cache tells it about each access by giving the set, the way, and whether the access was a hit or a fill of a way after a miss. The block answers with the victim way for whichever set the cache is querying.

A parameter fixes one of three policies when the block is built:
- **Binary-tree pseudo-LRU.** Each set keeps N-1 direction bits.
- **Round-robin.** Each set keeps a pointer that moves one way forward on every fill.
- **Round-robin that skips the newest way.** Each set also records the way touched most recently. The victim steps past that way if the pointer lands on it.

Hits update the recency state. Only fills use up the victim position.

Top module: `victim_select`

## Requirements
- R1: Reset clears all per-set state to zero. After reset, the victim for every set is way 0 under every policy.
- R2: `victimWay` is combinational from the registered state of `qrySet`. An access changes that state from the clock edge that samples it. With no access and a steady `qrySet`, the victim does not change.
- R3: An access to one set never changes the victim reported for a different set.
- R4: The tree policy uses N-1 node bits in heap order. Node 0 is the root, and the children of node n are 2n+1 (the lower-numbered half) and 2n+2. A bit value of 0 selects the lower half and 1 the upper half. The victim is found by walking from the root, and the bit chosen at each level gives the next way-index bit, most significant bit first.
- R5: In tree mode, a hit or fill to way w sets every node on w's path to point away from w. Right after that access, the victim of that set is never w.
- R6: In round-robin mode, each fill advances the set's pointer by one modulo N, whatever `accWay` is. Starting from reset, the victims run 0, 1, …, N-1, 0.
- R7: In round-robin mode, hits leave the victim unchanged.
- R8: In skip mode, the victim is the pointer. If a way has been touched in the set since reset and the pointer equals that most recent way, the victim is pointer+1 modulo N instead. Right after an access to way w, the victim of that set is never w.
- R9: In skip mode, a fill sets the pointer to the pre-access victim plus one, modulo N. Both hits and fills record `accWay` as the most recent way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| accValid | input | 1 | An access is reported this cycle |
| accFill | input | 1 | 1: fill after a miss, 0: hit |
| accSet | input | $clog2(NUM_SETS) | Set of the access |
| accWay | input | $clog2(NUM_WAYS) | Way hit or filled |
| qrySet | input | $clog2(NUM_SETS) | Set whose victim is requested |
| victimWay | output | $clog2(NUM_WAYS) | Victim way for `qrySet` |

## Verification
The bound checker watches several properties on every cycle:
- the victim of an untouched set stays the same;
- the victim stays steady when no access is reported;
- the way just touched is never the victim, in the tree and skip modes;
- round-robin hits hold the pointer;
- round-robin fills step the pointer by one.

Some behaviour only shows in the bench scenarios. These are the exact tree-walk victims after mixed hit and fill orders, the skip-mode pointer jump and its wrap, the full round-robin cycle, and the all-zero state after a reset in the middle of traffic.

// File: rtl/repl_pkg.sv
package repl_pkg;

  typedef enum logic [1:0] {
    POL_PLRU = 2'd0,
    POL_FIFO = 2'd1,
    POL_NLRU = 2'd2
  } policy_e;

  // strobes from control to datapath
  typedef struct packed {
    logic touch;    // recency update (hit or fill)
    logic advance;  // replacement consumed (fill)
  } strobe_t;

endpackage

// File: rtl/repl_ctrl.sv
module repl_ctrl (
  input  logic              accValid,
  input  logic              accFill,
  output repl_pkg::strobe_t strb
);

  always_comb begin
    strb.touch   = accValid;
    strb.advance = accValid & accFill;
  end

endmodule

// File: rtl/repl_plru_bank.sv
module repl_plru_bank #(
  parameter int NUM_WAYS = 8,
  parameter int NUM_SETS = 16,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int SET_W = $clog2(NUM_SETS),
  localparam int NODES = NUM_WAYS - 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             touch,
  input  logic [SET_W-1:0] accSet,
  input  logic [WAY_W-1:0] accWay,
  input  logic [SET_W-1:0] qrySet,
  output logic [WAY_W-1:0] victimWay
);

  logic [NODES-1:0] treeQ [NUM_SETS];

  // walk from the root following each node bit
  function automatic logic [WAY_W-1:0] walkTree(input logic [NODES-1:0] t);
    logic [WAY_W-1:0] way;
    int node;
    way  = '0;
    node = 0;
    for (int lvl = 0; lvl < WAY_W; lvl++) begin
      way[WAY_W-1-lvl] = t[node];
      node = 2 * node + 1 + int'(t[node]);
    end
    return way;
  endfunction

  // point every node on the path away from the touched way
  function automatic logic [NODES-1:0] pointAway(input logic [NODES-1:0] t,
                                                 input logic [WAY_W-1:0] w);
    logic [NODES-1:0] nt;
    int node;
    nt   = t;
    node = 0;
    for (int lvl = 0; lvl < WAY_W; lvl++) begin
      nt[node] = ~w[WAY_W-1-lvl];
      node = 2 * node + 1 + int'(w[WAY_W-1-lvl]);
    end
    return nt;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SETS; s++) treeQ[s] <= '0;
    end else if (touch) begin
      treeQ[accSet] <= pointAway(treeQ[accSet], accWay);
    end
  end

  always_comb victimWay = walkTree(treeQ[qrySet]);

endmodule

// File: rtl/repl_rr_bank.sv
module repl_rr_bank #(
  parameter int NUM_WAYS = 8,
  parameter int NUM_SETS = 16,
  parameter bit SKIP_MRU = 1'b0,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int SET_W = $clog2(NUM_SETS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             touch,
  input  logic             advance,
  input  logic [SET_W-1:0] accSet,
  input  logic [WAY_W-1:0] accWay,
  input  logic [SET_W-1:0] qrySet,
  output logic [WAY_W-1:0] victimWay
);

  logic [WAY_W-1:0] ptrQ    [NUM_SETS];
  logic [WAY_W-1:0] mruQ    [NUM_SETS];
  logic             mruVldQ [NUM_SETS];
  logic [WAY_W-1:0] accVictim;

  function automatic logic [WAY_W-1:0] pickWay(input logic [WAY_W-1:0] ptr,
                                               input logic [WAY_W-1:0] mru,
                                               input logic             vld);
    if (SKIP_MRU && vld && (ptr == mru)) return WAY_W'(ptr + 1'b1);
    return ptr;
  endfunction

  always_comb begin
    victimWay = pickWay(ptrQ[qrySet], mruQ[qrySet], mruVldQ[qrySet]);
    accVictim = pickWay(ptrQ[accSet], mruQ[accSet], mruVldQ[accSet]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        ptrQ[s]    <= '0;
        mruQ[s]    <= '0;
        mruVldQ[s] <= 1'b0;
      end
    end else begin
      if (advance) ptrQ[accSet] <= WAY_W'(accVictim + 1'b1);
      if (touch) begin
        mruQ[accSet]    <= accWay;
        mruVldQ[accSet] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/repl_datapath.sv
module repl_datapath #(
  parameter int NUM_WAYS = 8,
  parameter int NUM_SETS = 16,
  parameter repl_pkg::policy_e POLICY = repl_pkg::POL_PLRU,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int SET_W = $clog2(NUM_SETS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  repl_pkg::strobe_t strb,
  input  logic [SET_W-1:0]  accSet,
  input  logic [WAY_W-1:0]  accWay,
  input  logic [SET_W-1:0]  qrySet,
  output logic [WAY_W-1:0]  victimWay
);

  if (POLICY == repl_pkg::POL_PLRU) begin : g_tree
    logic unusedAdvance;
    assign unusedAdvance = strb.advance;
    repl_plru_bank #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS)) i_bank (
      .clk(clk), .rstN(rstN), .touch(strb.touch),
      .accSet(accSet), .accWay(accWay), .qrySet(qrySet), .victimWay(victimWay)
    );
  end else begin : g_ring
    repl_rr_bank #(
      .NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS),
      .SKIP_MRU(POLICY == repl_pkg::POL_NLRU)
    ) i_bank (
      .clk(clk), .rstN(rstN), .touch(strb.touch), .advance(strb.advance),
      .accSet(accSet), .accWay(accWay), .qrySet(qrySet), .victimWay(victimWay)
    );
  end

endmodule

// File: rtl/victim_select.sv
module victim_select #(
  parameter int NUM_WAYS = 8,
  parameter int NUM_SETS = 16,
  parameter repl_pkg::policy_e POLICY = repl_pkg::POL_PLRU,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int SET_W = $clog2(NUM_SETS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             accValid,
  input  logic             accFill,
  input  logic [SET_W-1:0] accSet,
  input  logic [WAY_W-1:0] accWay,
  input  logic [SET_W-1:0] qrySet,
  output logic [WAY_W-1:0] victimWay
);

  repl_pkg::strobe_t strb;

  repl_ctrl i_ctrl (
    .accValid(accValid), .accFill(accFill), .strb(strb)
  );

  repl_datapath #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS), .POLICY(POLICY)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .accSet(accSet), .accWay(accWay),
    .qrySet(qrySet), .victimWay(victimWay)
  );

endmodule

// File: rtl/victim_select_chk.sv
module victim_select_chk #(
  parameter int NUM_WAYS = 8,
  parameter int NUM_SETS = 16,
  parameter repl_pkg::policy_e POLICY = repl_pkg::POL_PLRU,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int SET_W = $clog2(NUM_SETS)
) (
  input logic             clk,
  input logic             rstN,
  input logic             accValid,
  input logic             accFill,
  input logic [SET_W-1:0] accSet,
  input logic [WAY_W-1:0] accWay,
  input logic [SET_W-1:0] qrySet,
  input logic [WAY_W-1:0] victimWay
);

  AST_QUIET_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |=> (qrySet == $past(qrySet)) -> (victimWay == $past(victimWay))); // R2

  AST_OTHER_SET_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accSet != qrySet) |=>
      (qrySet == $past(qrySet)) -> (victimWay == $past(victimWay))); // R3

  if (POLICY == repl_pkg::POL_FIFO) begin : g_fifo
    AST_HIT_HOLDS_PTR: assert property (@(posedge clk) disable iff (!rstN)
      (accValid && !accFill && accSet == qrySet) |=>
        (qrySet == $past(qrySet)) -> (victimWay == $past(victimWay))); // R7

    AST_FILL_STEPS: assert property (@(posedge clk) disable iff (!rstN)
      (accValid && accFill && accSet == qrySet) |=>
        (qrySet == $past(qrySet)) -> (victimWay == WAY_W'($past(victimWay) + 1'b1))); // R6
  end else begin : g_recency
    AST_TOUCHED_NOT_VICTIM: assert property (@(posedge clk) disable iff (!rstN)
      accValid |=> (qrySet == $past(accSet)) -> (victimWay != $past(accWay))); // R5 R8
  end

endmodule

bind victim_select victim_select_chk #(
  .NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS), .POLICY(POLICY)
) i_chk (
  .clk(clk), .rstN(rstN), .accValid(accValid), .accFill(accFill),
  .accSet(accSet), .accWay(accWay), .qrySet(qrySet), .victimWay(victimWay)
);

// File: tb/test_victim_select.sv
module test_victim_select;

  logic clk = 1'b0;
  logic rstN;
  logic accValid, accFill;
  logic [1:0] accSet, accWay, qrySet;
  logic [1:0] vicPlru, vicFifo, vicNlru;
  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  victim_select #(.NUM_WAYS(4), .NUM_SETS(4), .POLICY(repl_pkg::POL_PLRU)) i_victim_select (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accFill(accFill),
    .accSet(accSet), .accWay(accWay), .qrySet(qrySet), .victimWay(vicPlru));
  victim_select #(.NUM_WAYS(4), .NUM_SETS(4), .POLICY(repl_pkg::POL_FIFO)) i_victim_select_fifo (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accFill(accFill),
    .accSet(accSet), .accWay(accWay), .qrySet(qrySet), .victimWay(vicFifo));
  victim_select #(.NUM_WAYS(4), .NUM_SETS(4), .POLICY(repl_pkg::POL_NLRU)) i_victim_select_nlru (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accFill(accFill),
    .accSet(accSet), .accWay(accWay), .qrySet(qrySet), .victimWay(vicNlru));

  // {valid, fill, set, way, query, expTree, expRing, expSkip}
  localparam int NV = 11;
  localparam logic [13:0] VECS [NV] = '{
    {1'b1, 1'b0, 2'd1, 2'd0, 2'd1, 2'd2, 2'd0, 2'd1},
    {1'b1, 1'b1, 2'd1, 2'd2, 2'd1, 2'd1, 2'd1, 2'd3},
    {1'b1, 1'b0, 2'd1, 2'd1, 2'd1, 2'd3, 2'd1, 2'd2},
    {1'b1, 1'b1, 2'd1, 2'd3, 2'd1, 2'd0, 2'd2, 2'd0},
    {1'b1, 1'b0, 2'd2, 2'd3, 2'd1, 2'd0, 2'd2, 2'd0},
    {1'b1, 1'b1, 2'd1, 2'd0, 2'd1, 2'd2, 2'd3, 2'd1},
    {1'b1, 1'b1, 2'd1, 2'd2, 2'd1, 2'd1, 2'd0, 2'd3},
    {1'b0, 1'b0, 2'd0, 2'd0, 2'd2, 2'd0, 2'd0, 2'd0},
    {1'b1, 1'b0, 2'd2, 2'd0, 2'd2, 2'd2, 2'd0, 2'd1},
    {1'b1, 1'b0, 2'd2, 2'd1, 2'd2, 2'd2, 2'd0, 2'd0},
    {1'b1, 1'b1, 2'd1, 2'd1, 2'd1, 2'd3, 2'd1, 2'd0}
  };

  task automatic check(input logic [1:0] act, input logic [1:0] exp, input string req);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic access(input logic v, input logic f, input logic [1:0] s,
                        input logic [1:0] w, input logic [1:0] q);
    @(negedge clk);
    accValid = v; accFill = f; accSet = s; accWay = w; qrySet = q;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    tests++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    rstN = 1'b0; accValid = 1'b0; accFill = 1'b0;
    accSet = '0; accWay = '0; qrySet = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: every set starts at way 0
    for (int s = 0; s < 4; s++) begin
      @(negedge clk) qrySet = 2'(s);
      #1;
      check(vicPlru, 2'd0, "R1 tree reset");
      check(vicFifo, 2'd0, "R1 ring reset");
      check(vicNlru, 2'd0, "R1 skip reset");
    end

    // table: R4 R5 tree walk, R6 R7 ring, R8 R9 skip, R3 other set
    for (int i = 0; i < NV; i++) begin
      access(VECS[i][13], VECS[i][12], VECS[i][11:10], VECS[i][9:8], VECS[i][7:6]);
      check(vicPlru, VECS[i][5:4], "R4 R5 tree vector");
      check(vicFifo, VECS[i][3:2], "R6 R7 ring vector");
      check(vicNlru, VECS[i][1:0], "R8 R9 skip vector");
    end
    accValid = 1'b0;

    // R2: an access is not visible before the sampling edge
    @(negedge clk);
    accValid = 1'b1; accFill = 1'b0; accSet = 2'd0; accWay = 2'd0; qrySet = 2'd0;
    #1;
    check(vicPlru, 2'd0, "R2 tree before edge");
    check(vicNlru, 2'd0, "R2 skip before edge");
    @(posedge clk);
    #1;
    check(vicPlru, 2'd2, "R2 tree after edge");
    check(vicFifo, 2'd0, "R2 R7 ring hit");
    check(vicNlru, 2'd1, "R2 R8 skip after edge");

    // R6 full ring cycle on set 3, fills always name way 2
    begin
      logic [1:0] expRing [4] = '{2'd1, 2'd2, 2'd3, 2'd0};
      logic [1:0] expSkip [4] = '{2'd1, 2'd3, 2'd0, 2'd1};
      for (int k = 0; k < 4; k++) begin
        access(1'b1, 1'b1, 2'd3, 2'd2, 2'd3);
        check(vicFifo, expRing[k], "R6 ring wrap");
        check(vicNlru, expSkip[k], "R9 skip wrap");
        check(vicPlru, 2'd0, "R5 tree repeated fill");
      end
    end
    @(negedge clk) accValid = 1'b0;

    // R1: reset in the middle of traffic
    rstN = 1'b0;
    @(negedge clk) rstN = 1'b1; qrySet = 2'd1;
    #1;
    check(vicPlru, 2'd0, "R1 tree re-reset");
    check(vicFifo, 2'd0, "R1 ring re-reset");
    check(vicNlru, 2'd0, "R1 skip re-reset");

    finish_run();
  end

endmodule